// File: doc/BRIEF.md
# ADC Conversion Start and End-of-Conversion Sequencer

This block decides when a successive-approximation converter is told to sample, and how many times. A 2-bit clock-mode input picks the trigger source and the acquisition timing. Two modes take their trigger from an active-low conversion-start pin: one runs the whole requested sequence per pin edge, the other runs one channel per edge. The other two modes take their trigger from a one-cycle strobe that marks a write to the conversion register. In one of those, acquisition timing comes from the serial clock, and scanning and averaging are forced off. Each conversion is a one-cycle start pulse to the converter. The converter answers with a one-cycle done pulse.

The block keeps an active-low end-of-conversion flag. The flag drops when the whole requested sequence has finished, meaning every channel and every average. It rises again on a falling edge of chip select or of the conversion-start pin. It is held high in the externally timed mode. For every conversion the block also gives the positive input channel and the negative input, which is either the odd partner of an even channel or analog ground.

All inputs are synchronous to `clk_i`. An edge on either pin is seen at the first clock edge at which the pin is low after being high.

Top module: `conv_start_ctrl`

## Requirements
- R1: With `clk_mode_i`=2'b10, a one-cycle `conv_wr_i` in idle starts a full sequence. `start_o` goes high in the cycle after the strobe and fires N_ch × N_avg times, one per `sar_done_i`. A falling edge on `cnvst_n_i` starts nothing in this mode.
- R2: With `clk_mode_i`=2'b00, a falling edge on `cnvst_n_i` in idle starts the full sequence, and `ext_timing_o` is 0.
- R3: With `clk_mode_i`=2'b01, each falling edge on `cnvst_n_i` converts one channel, with all its averages, and then waits for the next edge. `eoc_n_o` stays high until the last channel is done.
- R4: With `clk_mode_i`=2'b11, `ext_timing_o`=1 and `scan_active_o`=`avg_active_o`=0. A `conv_wr_i` gives exactly one start whatever the scan and average settings are, and `eoc_n_o` is 1 at all times.
- R5: `eoc_n_o` goes low in the cycle after the `sar_done_i` that ends the final conversion of a sequence, and not before.
- R6: A falling edge of `cs_n_i` or `cnvst_n_i` drives `eoc_n_o` high in the following cycle.
- R7: When a sequence completes in the same cycle as a falling edge of `cs_n_i`, the edge wins and `eoc_n_o` stays high.
- R8: A trigger that arrives while a conversion is in progress is ignored and adds no start.
- R9: With `diff_en_i`=1, inputs pair as (0,1), (2,3), (4,5), (6,7). `pos_ch_o` is even, `neg_ch_o` = `pos_ch_o`+1 and `neg_gnd_o`=0. With `diff_en_i`=0, `pos_ch_o` is the selected channel and `neg_gnd_o`=1.
- R10: Scanning converts channels from 0 up to `chan_sel_i`, in steps of 2 when `diff_en_i`=1, and otherwise converts `chan_sel_i` alone. Averaging repeats each channel 4 << `navg_i` times.
- R11: After reset `eoc_n_o`=1 and `start_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_mode_i | input | 2 | Clock mode: 00 pin/full, 01 pin/per channel, 10 register/internal, 11 register/external |
| conv_wr_i | input | 1 | One-cycle strobe: conversion register written |
| cs_n_i | input | 1 | Chip select, active low |
| cnvst_n_i | input | 1 | Conversion-start pin, active low |
| chan_sel_i | input | CH_W | Selected channel (highest channel when scanning) |
| scan_en_i | input | 1 | Scan request |
| avg_en_i | input | 1 | Averaging request |
| navg_i | input | NAVG_W | Average count exponent, 4 << navg_i |
| diff_en_i | input | 1 | Differential input pairing |
| sar_done_i | input | 1 | Converter finished one conversion |
| start_o | output | 1 | One-cycle conversion start |
| ext_timing_o | output | 1 | Acquisition timed externally |
| scan_active_o | output | 1 | Scan allowed in current mode |
| avg_active_o | output | 1 | Averaging allowed in current mode |
| pos_ch_o | output | CH_W | Positive input channel |
| neg_ch_o | output | CH_W | Negative input channel when differential |
| neg_gnd_o | output | 1 | Negative input tied to analog ground |
| eoc_n_o | output | 1 | End of conversion, active low |

## Verification
The end of the final conversion and a chip-select falling edge can meet in one cycle, and one of them must be chosen to set the end-of-conversion flag. The bench turns off its converter model and drives `sar_done_i` by hand. It lowers `cs_n_i` in the same cycle as the last done pulse and expects `eoc_n_o` to stay high. It then repeats the same completion without the edge and expects `eoc_n_o` to fall, which shows the first result came from the edge winning and not from a missed completion.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic [1:0] {
    MODE_PIN_SEQ = 2'b00,
    MODE_PIN_CH  = 2'b01,
    MODE_REG_INT = 2'b10,
    MODE_REG_EXT = 2'b11
  } clk_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_WAIT = 2'b10
  } seq_st_e;
endpackage

// File: rtl/cst_fall_det.sv
module cst_fall_det #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[i] <= 1'b1;
      else         prev_q[i] <= sig_i[i];
    end
    assign fall_o[i] = prev_q[i] & ~sig_i[i];
  end
endmodule

// File: rtl/cst_trig_sel.sv
module cst_trig_sel
  import conv_seq_pkg::*;
(
  input  clk_mode_e mode_i,
  input  seq_st_e   state_i,
  input  logic      pin_fall_i,
  input  logic      reg_wr_i,
  input  logic      scan_req_i,
  input  logic      avg_req_i,
  output logic      trig_o,
  output logic      ext_timing_o,
  output logic      scan_ok_o,
  output logic      avg_ok_o
);
  logic pin_src;

  assign pin_src      = (mode_i == MODE_PIN_SEQ) || (mode_i == MODE_PIN_CH);
  assign ext_timing_o = (mode_i == MODE_REG_EXT);
  assign scan_ok_o    = scan_req_i & ~ext_timing_o;
  assign avg_ok_o     = avg_req_i & ~ext_timing_o;

  always_comb begin
    unique case (state_i)
      ST_IDLE: trig_o = pin_src ? pin_fall_i : reg_wr_i;
      ST_WAIT: trig_o = pin_fall_i;
      default: trig_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cst_seq_ctrl.sv
module cst_seq_ctrl
  import conv_seq_pkg::*;
#(
  parameter int CH_W     = 3,
  parameter int NAVG_W   = 2,
  parameter int AVG_BASE = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            trig_i,
  input  clk_mode_e       mode_i,
  input  logic [CH_W-1:0] chan_i,
  input  logic            scan_ok_i,
  input  logic            avg_ok_i,
  input  logic [NAVG_W-1:0] navg_i,
  input  logic            diff_i,
  input  logic            sar_done_i,
  output logic            start_o,
  output logic [CH_W-1:0] ch_o,
  output logic            diff_o,
  output clk_mode_e       mode_o,
  output logic            seq_done_o,
  output seq_st_e         state_o
);
  localparam int AVG_W = (1 << NAVG_W) + AVG_BASE;

  seq_st_e          state_q;
  clk_mode_e        mode_q;
  logic             start_q, diff_q;
  logic [CH_W-1:0]  ch_q, last_q;
  logic [AVG_W-1:0] avg_cnt_q, avg_lim_q;

  logic [CH_W-1:0]  ch_last_n, ch_first_n, ch_step;
  logic [AVG_W-1:0] avg_lim_n, avg_pow;
  logic             conv_last, ch_end;

  assign ch_last_n  = diff_i ? {chan_i[CH_W-1:1], 1'b0} : chan_i;
  assign ch_first_n = scan_ok_i ? '0 : ch_last_n;
  assign avg_pow    = AVG_W'(1) << (int'(navg_i) + AVG_BASE);
  assign avg_lim_n  = avg_ok_i ? (avg_pow - AVG_W'(1)) : '0;
  assign ch_step    = diff_q ? CH_W'(2) : CH_W'(1);

  assign conv_last  = (avg_cnt_q == avg_lim_q);
  assign ch_end     = (ch_q == last_q);
  assign seq_done_o = (state_q == ST_RUN) && sar_done_i && conv_last && ch_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      mode_q    <= MODE_REG_INT;
      start_q   <= 1'b0;
      diff_q    <= 1'b0;
      ch_q      <= '0;
      last_q    <= '0;
      avg_cnt_q <= '0;
      avg_lim_q <= '0;
    end else begin
      start_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (trig_i) begin
          mode_q    <= mode_i;
          diff_q    <= diff_i;
          ch_q      <= ch_first_n;
          last_q    <= ch_last_n;
          avg_cnt_q <= '0;
          avg_lim_q <= avg_lim_n;
          start_q   <= 1'b1;
          state_q   <= ST_RUN;
        end
        ST_RUN: if (sar_done_i) begin
          if (!conv_last) begin
            avg_cnt_q <= avg_cnt_q + AVG_W'(1);
            start_q   <= 1'b1;
          end else if (!ch_end) begin
            avg_cnt_q <= '0;
            ch_q      <= ch_q + ch_step;
            if (mode_q == MODE_PIN_CH) state_q <= ST_WAIT;
            else                       start_q <= 1'b1;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_WAIT: if (trig_i) begin
          start_q <= 1'b1;
          state_q <= ST_RUN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign start_o = start_q;
  assign ch_o    = ch_q;
  assign diff_o  = diff_q;
  assign mode_o  = mode_q;
  assign state_o = state_q;

  AST_START_ONLY_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> state_q == ST_RUN); // R8
  AST_WAIT_PER_CH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WAIT |-> mode_q == MODE_PIN_CH); // R3
endmodule

// File: rtl/cst_eoc_flag.sv
module cst_eoc_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_hit_i,
  input  logic seq_done_i,
  input  logic ext_seq_i,
  input  logic ext_now_i,
  output logic eoc_n_o
);
  logic eoc_q;

  // a falling pin edge outranks a completion in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       eoc_q <= 1'b1;
    else if (edge_hit_i)               eoc_q <= 1'b1;
    else if (seq_done_i && !ext_seq_i) eoc_q <= 1'b0;
  end

  assign eoc_n_o = eoc_q | ext_now_i;
endmodule

// File: rtl/cst_pair_map.sv
module cst_pair_map #(
  parameter int CH_W = 3
) (
  input  logic [CH_W-1:0] ch_i,
  input  logic            diff_i,
  output logic [CH_W-1:0] pos_o,
  output logic [CH_W-1:0] neg_o,
  output logic            neg_gnd_o
);
  assign pos_o     = diff_i ? {ch_i[CH_W-1:1], 1'b0} : ch_i;
  assign neg_o     = diff_i ? {ch_i[CH_W-1:1], 1'b1} : '0;
  assign neg_gnd_o = ~diff_i;
endmodule

// File: rtl/conv_start_ctrl.sv
module conv_start_ctrl
  import conv_seq_pkg::*;
#(
  parameter int CH_W     = 3,
  parameter int NAVG_W   = 2,
  parameter int AVG_BASE = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        clk_mode_i,
  input  logic              conv_wr_i,
  input  logic              cs_n_i,
  input  logic              cnvst_n_i,
  input  logic [CH_W-1:0]   chan_sel_i,
  input  logic              scan_en_i,
  input  logic              avg_en_i,
  input  logic [NAVG_W-1:0] navg_i,
  input  logic              diff_en_i,
  input  logic              sar_done_i,
  output logic              start_o,
  output logic              ext_timing_o,
  output logic              scan_active_o,
  output logic              avg_active_o,
  output logic [CH_W-1:0]   pos_ch_o,
  output logic [CH_W-1:0]   neg_ch_o,
  output logic              neg_gnd_o,
  output logic              eoc_n_o
);
  clk_mode_e       mode_now, mode_seq;
  seq_st_e         state;
  logic [1:0]      fall;
  logic            cs_fall, pin_fall, edge_hit;
  logic            trig, scan_ok, avg_ok, seq_done, diff_seq;
  logic [CH_W-1:0] ch_cur;

  assign mode_now = clk_mode_e'(clk_mode_i);

  cst_fall_det #(.W(2)) u_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  ({cs_n_i, cnvst_n_i}),
    .fall_o (fall)
  );
  assign cs_fall  = fall[1];
  assign pin_fall = fall[0];
  assign edge_hit = cs_fall | pin_fall;

  cst_trig_sel u_trig (
    .mode_i       (mode_now),
    .state_i      (state),
    .pin_fall_i   (pin_fall),
    .reg_wr_i     (conv_wr_i),
    .scan_req_i   (scan_en_i),
    .avg_req_i    (avg_en_i),
    .trig_o       (trig),
    .ext_timing_o (ext_timing_o),
    .scan_ok_o    (scan_ok),
    .avg_ok_o     (avg_ok)
  );
  assign scan_active_o = scan_ok;
  assign avg_active_o  = avg_ok;

  cst_seq_ctrl #(.CH_W(CH_W), .NAVG_W(NAVG_W), .AVG_BASE(AVG_BASE)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_i     (trig),
    .mode_i     (mode_now),
    .chan_i     (chan_sel_i),
    .scan_ok_i  (scan_ok),
    .avg_ok_i   (avg_ok),
    .navg_i     (navg_i),
    .diff_i     (diff_en_i),
    .sar_done_i (sar_done_i),
    .start_o    (start_o),
    .ch_o       (ch_cur),
    .diff_o     (diff_seq),
    .mode_o     (mode_seq),
    .seq_done_o (seq_done),
    .state_o    (state)
  );

  cst_eoc_flag u_eoc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .edge_hit_i (edge_hit),
    .seq_done_i (seq_done),
    .ext_seq_i  (mode_seq == MODE_REG_EXT),
    .ext_now_i  (ext_timing_o),
    .eoc_n_o    (eoc_n_o)
  );

  cst_pair_map #(.CH_W(CH_W)) u_pair (
    .ch_i      (ch_cur),
    .diff_i    (diff_seq),
    .pos_o     (pos_ch_o),
    .neg_o     (neg_ch_o),
    .neg_gnd_o (neg_gnd_o)
  );

  AST_EOC_FALL_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(eoc_n_o) |-> ($past(seq_done) || $past(clk_mode_i) == 2'b11)); // R5
  AST_EOC_EDGE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(edge_hit) |-> eoc_n_o); // R6
  AST_PAIR_ODD_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && diff_seq) |-> (!pos_ch_o[0] && neg_ch_o == pos_ch_o + CH_W'(1) && !neg_gnd_o)); // R9
  AST_EXT_HOLD_EOC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_mode_i == 2'b11) |-> (eoc_n_o && !scan_active_o && !avg_active_o)); // R4
endmodule

// File: tb/tb_conv_start_ctrl.sv
module tb_conv_start_ctrl;
  localparam int LAT = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] clk_mode = 2'b10;
  logic       conv_wr = 1'b0, cs_n = 1'b1, cnvst_n = 1'b1;
  logic [2:0] chan_sel = '0;
  logic       scan_en = 1'b0, avg_en = 1'b0, diff_en = 1'b0;
  logic [1:0] navg = '0;
  logic       sar_auto = 1'b1, sar_man = 1'b0;
  logic [LAT-1:0] sar_pipe = '0;
  logic       sar_done;
  logic       start, ext_t, scan_act, avg_act, neg_gnd, eoc_n;
  logic [2:0] pos_ch, neg_ch;

  int n_chk = 0, n_fail = 0, n_start = 0;
  logic [2:0] pos_log [16];
  logic [2:0] neg_log [16];
  logic       gnd_log [16];
  bit done_flag = 0;

  always #10 clk = ~clk;

  conv_start_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .clk_mode_i(clk_mode), .conv_wr_i(conv_wr),
    .cs_n_i(cs_n), .cnvst_n_i(cnvst_n), .chan_sel_i(chan_sel), .scan_en_i(scan_en),
    .avg_en_i(avg_en), .navg_i(navg), .diff_en_i(diff_en), .sar_done_i(sar_done),
    .start_o(start), .ext_timing_o(ext_t), .scan_active_o(scan_act),
    .avg_active_o(avg_act), .pos_ch_o(pos_ch), .neg_ch_o(neg_ch),
    .neg_gnd_o(neg_gnd), .eoc_n_o(eoc_n)
  );

  // converter model: done LAT cycles after each start
  always @(negedge clk) begin
    sar_pipe <= {sar_pipe[LAT-2:0], start};
    if (rst_n && start) begin
      pos_log[n_start[3:0]] = pos_ch;
      neg_log[n_start[3:0]] = neg_ch;
      gnd_log[n_start[3:0]] = neg_gnd;
      n_start = n_start + 1;
    end
  end
  assign sar_done = (sar_auto & sar_pipe[LAT-1]) | sar_man;

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_wr();   conv_wr = 1'b1; tick(); conv_wr = 1'b0; endtask
  task automatic pulse_pin();  cnvst_n = 1'b0; tick(); cnvst_n = 1'b1; endtask
  task automatic pulse_cs();   cs_n    = 1'b0; tick(); cs_n    = 1'b1; endtask

  task automatic t_reset();
    chk("R11 eoc_n", eoc_n, 1);
    chk("R11 start", start, 0);
    rst_n = 1'b1;
    tick(2);
    chk("R11 eoc_n after release", eoc_n, 1);
  endtask

  task automatic t_reg_scan();
    int b;
    clk_mode = 2'b10; scan_en = 1'b1; chan_sel = 3'd3; diff_en = 1'b0;
    b = n_start;
    pulse_wr();
    chk("R1 start next cycle", start, 1);
    tick(4);
    chk("R5 eoc high mid sequence", eoc_n, 1);
    tick(30);
    chk("R1 start count", n_start - b, 4);
    for (int i = 0; i < 4; i++) chk("R10 scan order", pos_log[(b + i) % 16], i);
    chk("R9 single-ended gnd", gnd_log[(b + 3) % 16], 1);
    chk("R5 eoc low at end", eoc_n, 0);
    pulse_cs();
    chk("R6 eoc high after cs fall", eoc_n, 1);
    scan_en = 1'b0;
  endtask

  task automatic t_reg_ignores_pin();
    int b;
    clk_mode = 2'b10; chan_sel = 3'd6; pulse_wr(); tick(10);
    chk("R5 eoc low", eoc_n, 0);
    chk("R9 single pos", pos_log[(n_start - 1) % 16], 6);
    b = n_start;
    pulse_pin();
    chk("R6 eoc high after pin fall", eoc_n, 1);
    tick(10);
    chk("R1 pin ignored in reg mode", n_start - b, 0);
  endtask

  task automatic t_pin_seq();
    int b;
    clk_mode = 2'b00; avg_en = 1'b1; navg = 2'd1; chan_sel = 3'd2;
    tick();
    chk("R2 internal timing", ext_t, 0);
    b = n_start;
    pulse_pin(); tick(40);
    chk("R10 avg count 8", n_start - b, 8);
    chk("R2 eoc low after sequence", eoc_n, 0);
    avg_en = 1'b0; navg = '0;
  endtask

  task automatic t_pin_each();
    int b;
    clk_mode = 2'b01; scan_en = 1'b1; chan_sel = 3'd2;
    pulse_cs();
    b = n_start;
    for (int k = 1; k <= 3; k++) begin
      pulse_pin(); tick(10);
      chk("R3 one channel per edge", n_start - b, k);
      chk("R3 channel", pos_log[(b + k - 1) % 16], k - 1);
      chk("R3 eoc", eoc_n, (k == 3) ? 0 : 1);
    end
    scan_en = 1'b0;
  endtask

  task automatic t_ext();
    int b;
    clk_mode = 2'b11; scan_en = 1'b1; avg_en = 1'b1; chan_sel = 3'd3;
    tick();
    chk("R4 ext timing", ext_t, 1);
    chk("R4 scan off", scan_act, 0);
    chk("R4 avg off", avg_act, 0);
    chk("R4 eoc held", eoc_n, 1);
    b = n_start;
    pulse_wr(); tick(20);
    chk("R4 single start", n_start - b, 1);
    chk("R4 eoc held after", eoc_n, 1);
    scan_en = 1'b0; avg_en = 1'b0;
  endtask

  task automatic t_busy();
    int b;
    clk_mode = 2'b10; avg_en = 1'b1; navg = 2'd0; chan_sel = 3'd1;
    b = n_start;
    pulse_wr(); tick(2);
    pulse_wr(); tick(3); pulse_wr();
    tick(30);
    chk("R8 extra triggers ignored", n_start - b, 4);
    avg_en = 1'b0;
  endtask

  task automatic t_diff();
    int b;
    clk_mode = 2'b10; diff_en = 1'b1; scan_en = 1'b1; chan_sel = 3'd5;
    b = n_start;
    pulse_wr(); tick(30);
    chk("R10 diff pair count", n_start - b, 3);
    for (int i = 0; i < 3; i++) begin
      chk("R9 diff pos", pos_log[(b + i) % 16], 2 * i);
      chk("R9 diff neg", neg_log[(b + i) % 16], 2 * i + 1);
      chk("R9 diff gnd", gnd_log[(b + i) % 16], 0);
    end
    diff_en = 1'b0; scan_en = 1'b0;
  endtask

  task automatic t_collide();
    int b;
    clk_mode = 2'b10; chan_sel = 3'd0;
    sar_auto = 1'b0;
    pulse_cs();
    b = n_start;
    pulse_wr(); tick(3);
    chk("R7 start issued", n_start - b, 1);
    sar_man = 1'b1; cs_n = 1'b0; tick();
    sar_man = 1'b0; cs_n = 1'b1;
    chk("R7 edge wins over completion", eoc_n, 1);
    tick(2);
    chk("R7 eoc stays high", eoc_n, 1);
    pulse_wr(); tick(3);
    chk("R7 sequence closed", n_start - b, 2);
    sar_man = 1'b1; tick(); sar_man = 1'b0;
    chk("R5 completion alone lowers eoc", eoc_n, 0);
    tick(LAT + 2);
    sar_auto = 1'b1;
  endtask

  initial begin
    tick(3);
    t_reset();
    t_reg_scan();
    t_reg_ignores_pin();
    t_pin_seq();
    t_pin_each();
    t_ext();
    t_busy();
    t_diff();
    t_collide();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule